// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim and Complete

The block gathers level-type interrupt request lines from a set of sources and fans them out to a fixed set of target contexts. Every context owns one interrupt output, a bitmap that selects the sources it listens to, and a threshold. Each source carries a small software-set priority. Each source also has two bits of tracking state: a pending flag that follows its request line, and a claimed flag that keeps it away from all contexts while a handler is servicing it.

Software talks to the block through a word-wide register port. One cycle after an access, the port returns read data and an error flag. A handler reads its context's claim register to take ownership of the lowest-numbered source that qualifies. When the handler is done, it writes that source number back to any context's claim register. Priority does not rank sources. It only decides whether a source passes a context's threshold.

Top module: `irq_hub`

## Requirements
- R1: A write to the priority register of source i (byte address 0x000 + 4*i) stores only bits [2:0] of the data. A read of that address returns the stored value, zero-extended.
- R2: A source is eligible for a context only if all four conditions hold: it is pending, it is not claimed, its bit is set in that context's enable bitmap, and its priority is strictly greater than that context's threshold. Source 0 is reserved and is never eligible, whatever its input, enable or priority.
- R3: Output irq_o[c] is a register. It goes high one clock after context c first has an eligible source, and it goes low one clock after the last one stops being eligible. Contexts tagged with a machine (3) or supervisor (1) mode drive their output. Contexts tagged user (0) or hypervisor (2) hold it low. The default tags are: context 0 machine, context 1 supervisor, context 2 user.
- R4: A read of context c's claim register (0x404 + 0x10*c) returns the lowest-numbered eligible source, even when a higher-numbered eligible source has a higher priority. The same access clears that source's pending bit and sets its claimed bit. When nothing is eligible, the read returns 0 and changes no state.
- R5: A claimed source is eligible for no context. A write of value v to any context's claim register clears the claimed bit of source v when v is below the source count, whichever context made the claim. A write with v at or above the source count is ignored.
- R6: A write to context c's threshold register (0x400 + 0x10*c) takes effect only if the full 32-bit value is at most the maximum priority (7). Any larger value leaves the threshold unchanged.
- R7: The pending word at 0x100 is read-only, with bit i holding source i. A write to it changes nothing and raises the error flag.
- R8: An access is an error, with the error flag high one cycle later and read data 0, in each of these cases: the address is not 4-byte aligned; the address falls in no register; the address is an enable word at or beyond the word count; the address is a context offset other than 0 or 4.
- R9: A rising edge on a source's input sets its pending bit. A falling edge clears it. A source that stays high after being claimed does not become pending again until its input falls and rises once more.
- R10: Synchronous active-high reset clears all priorities, pending and claimed bits, enables, thresholds, outputs and the response registers.
- R11: Context c's enable bitmap sits at 0x200 + 0x20*c. Only the low source-count bits are stored, and a read returns them zero-extended. A read or write response appears on acc_rdata and acc_err one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Interrupt request levels, one per source |
| acc_en | input | 1 | Register access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, one cycle after the access |
| acc_err | output | 1 | Access error, one cycle after the access |
| irq_o | output | N_CTX | Per-context interrupt outputs |

## Verification
The bench targets the claim ordering, where source 4 has a higher priority than source 2 but source 2 must still be returned first. A design that ranked sources by priority would return 4. Completion is driven through a different context than the one that claimed, and with an out-of-range ID whose low bits name a claimed source. A design that checked ownership would leave the source stuck, and one that truncated the ID would release it. The bench also probes the strict threshold comparison at equality, the threshold boundary values 7 and 8, a source that stays high after being claimed, the reserved source 0, a user-mode context that must stay silent while it can still claim, and the one-cycle lag of the outputs. A design with an off-by-one in any of these would either show an interrupt too early or too late, or hand out the wrong ID.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned FW = 16;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } region_e;

    typedef struct packed {
        region_e         rg;
        logic [FW-1:0]   src;
        logic [FW-1:0]   ctx;
        logic [FW-1:0]   word;
    } dec_t;

    typedef enum logic [1:0] {
        MODE_U = 2'd0,
        MODE_S = 2'd1,
        MODE_H = 2'd2,
        MODE_M = 2'd3
    } ctx_mode_e;

    function automatic logic mode_drives(logic [1:0] m);
        return (m == MODE_M) || (m == MODE_S);
    endfunction

    function automatic int unsigned words_for(int unsigned n);
        return (n + 31) / 32;
    endfunction

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
    import irq_hub_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned N_SRC     = 8,
    parameter int unsigned N_CTX     = 3,
    parameter int unsigned PRIO_BASE = 32'h000,
    parameter int unsigned PEND_BASE = 32'h100,
    parameter int unsigned EN_BASE   = 32'h200,
    parameter int unsigned EN_STRIDE = 32'h20,
    parameter int unsigned CX_BASE   = 32'h400,
    parameter int unsigned CX_STRIDE = 32'h10
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int unsigned WORDS = words_for(N_SRC);
    localparam int unsigned EN_SH = $clog2(EN_STRIDE);
    localparam int unsigned CX_SH = $clog2(CX_STRIDE);

    always_comb begin
        logic [31:0] a;
        logic [31:0] off;
        logic [31:0] low;
        a   = 32'(addr);
        off = '0;
        low = '0;
        dec = '0;
        dec.rg = RG_NONE;
        if (a[1:0] == 2'b00) begin
            if (a >= PRIO_BASE && a < PRIO_BASE + 4 * N_SRC) begin
                off     = a - PRIO_BASE;
                dec.rg  = RG_PRIO;
                dec.src = FW'(off >> 2);
            end else if (a >= PEND_BASE && a < PEND_BASE + 4 * WORDS) begin
                off      = a - PEND_BASE;
                dec.rg   = RG_PEND;
                dec.word = FW'(off >> 2);
            end else if (a >= EN_BASE && a < EN_BASE + N_CTX * EN_STRIDE) begin
                off = a - EN_BASE;
                low = off & (EN_STRIDE - 1);
                if ((low >> 2) < WORDS) begin
                    dec.rg   = RG_EN;
                    dec.ctx  = FW'(off >> EN_SH);
                    dec.word = FW'(low >> 2);
                end
            end else if (a >= CX_BASE && a < CX_BASE + N_CTX * CX_STRIDE) begin
                off     = a - CX_BASE;
                low     = off & (CX_STRIDE - 1);
                dec.ctx = FW'(off >> CX_SH);
                if (low == 32'd0)      dec.rg = RG_THR;
                else if (low == 32'd4) dec.rg = RG_CLAIM;
            end
        end
    end

endmodule

// File: rtl/irq_hub_pick.sv
module irq_hub_pick #(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned SRC_W = 3
) (
    input  logic [N_SRC-1:0] elig,
    output logic             any,
    output logic [SRC_W-1:0] id
);
    always_comb begin
        any = |elig;
        id  = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i]) id = SRC_W'(i);
        end
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int unsigned N_SRC     = 8,
    parameter int unsigned N_CTX     = 3,
    parameter int unsigned PRIO_W    = 3,
    parameter int unsigned MAX_PRIO  = 7,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned PRIO_BASE = 32'h000,
    parameter int unsigned PEND_BASE = 32'h100,
    parameter int unsigned EN_BASE   = 32'h200,
    parameter int unsigned EN_STRIDE = 32'h20,
    parameter int unsigned CX_BASE   = 32'h400,
    parameter int unsigned CX_STRIDE = 32'h10,
    parameter logic [2*N_CTX-1:0] CTX_MODES = 6'b00_01_11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DW-1:0]     acc_wdata,
    output logic [DW-1:0]     acc_rdata,
    output logic              acc_err,
    output logic [N_CTX-1:0]  irq_o
);
    localparam int unsigned SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int unsigned CTX_W  = (N_CTX > 1) ? $clog2(N_CTX) : 1;
    localparam int unsigned WORDS  = words_for(N_SRC);
    localparam int unsigned WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int unsigned PAD    = WORDS * DW;

    logic [PRIO_W-1:0] prio_q [N_SRC];
    logic [PRIO_W-1:0] thr_q  [N_CTX];
    logic [N_SRC-1:0]  en_q   [N_CTX];
    logic [N_SRC-1:0]  pend_q, claim_q, src_q;
    logic [N_SRC-1:0]  pend_n, claim_n;

    dec_t              dec;
    logic [CTX_W-1:0]  ctx_sel;
    logic [SRC_W-1:0]  src_sel;
    logic [WORD_W-1:0] word_sel;

    irq_hub_decode #(
        .ADDR_W(ADDR_W), .N_SRC(N_SRC), .N_CTX(N_CTX),
        .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
        .EN_BASE(EN_BASE), .EN_STRIDE(EN_STRIDE),
        .CX_BASE(CX_BASE), .CX_STRIDE(CX_STRIDE)
    ) u_dec (
        .addr(acc_addr),
        .dec (dec)
    );

    assign ctx_sel  = dec.ctx[CTX_W-1:0];
    assign src_sel  = dec.src[SRC_W-1:0];
    assign word_sel = dec.word[WORD_W-1:0];

    // Per-context eligibility and lowest-index selection
    logic [N_CTX-1:0] ctx_any;
    logic [SRC_W-1:0] pick_id [N_CTX];

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        logic [N_SRC-1:0] above;
        logic [N_SRC-1:0] elig;
        always_comb begin
            for (int i = 0; i < N_SRC; i++) begin
                above[i] = (prio_q[i] > thr_q[c]);
            end
            elig    = pend_q & ~claim_q & en_q[c] & above;
            elig[0] = 1'b0;
        end
        irq_hub_pick #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_pick (
            .elig(elig),
            .any (ctx_any[c]),
            .id  (pick_id[c])
        );
    end

    // Access qualifiers
    logic             rd, wr, claim_rd, cl_hit, done_wr, pend_wr;
    logic [SRC_W-1:0] cl_id;

    assign rd       = acc_en && !acc_we;
    assign wr       = acc_en && acc_we;
    assign claim_rd = rd && (dec.rg == RG_CLAIM);
    assign cl_hit   = ctx_any[ctx_sel];
    assign cl_id    = pick_id[ctx_sel];
    assign done_wr  = wr && (dec.rg == RG_CLAIM) && (acc_wdata < N_SRC);
    assign pend_wr  = wr && (dec.rg == RG_PEND);

    // Pending and claimed next state
    always_comb begin
        logic [N_SRC-1:0] rise, fall;
        rise    = src_i & ~src_q;
        fall    = ~src_i & src_q;
        pend_n  = pend_q;
        claim_n = claim_q;
        if (claim_rd && cl_hit) begin
            pend_n[cl_id]  = 1'b0;
            claim_n[cl_id] = 1'b1;
        end
        if (done_wr) claim_n[acc_wdata[SRC_W-1:0]] = 1'b0;
        pend_n    = (pend_n & ~fall) | rise;
        pend_n[0] = 1'b0;
    end

    // Enable word merge and read mux
    logic [PAD-1:0] en_cur, en_new, pend_pad;
    logic [DW-1:0]  rd_n;
    logic           err_n;

    always_comb begin
        en_cur   = PAD'(en_q[ctx_sel]);
        en_new   = en_cur;
        en_new[DW*int'(word_sel) +: DW] = acc_wdata;
        pend_pad = PAD'(pend_q);
        rd_n     = '0;
        if (rd) begin
            unique case (dec.rg)
                RG_PRIO:  rd_n = DW'(prio_q[src_sel]);
                RG_PEND:  rd_n = pend_pad[DW*int'(word_sel) +: DW];
                RG_EN:    rd_n = en_cur[DW*int'(word_sel) +: DW];
                RG_THR:   rd_n = DW'(thr_q[ctx_sel]);
                RG_CLAIM: rd_n = cl_hit ? DW'(cl_id) : '0;
                default:  rd_n = '0;
            endcase
        end
        err_n = acc_en && ((dec.rg == RG_NONE) || pend_wr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SRC; i++) prio_q[i] <= '0;
            for (int c = 0; c < N_CTX; c++) begin
                thr_q[c] <= '0;
                en_q[c]  <= '0;
            end
            pend_q    <= '0;
            claim_q   <= '0;
            src_q     <= '0;
            irq_o     <= '0;
            acc_rdata <= '0;
            acc_err   <= 1'b0;
        end else begin
            src_q     <= src_i;
            pend_q    <= pend_n;
            claim_q   <= claim_n;
            acc_rdata <= rd_n;
            acc_err   <= err_n;
            if (wr) begin
                unique case (dec.rg)
                    RG_PRIO: prio_q[src_sel] <= acc_wdata[PRIO_W-1:0];
                    RG_EN:   en_q[ctx_sel]   <= en_new[N_SRC-1:0];
                    RG_THR:  if (acc_wdata <= MAX_PRIO) thr_q[ctx_sel] <= acc_wdata[PRIO_W-1:0];
                    default: ;
                endcase
            end
            for (int c = 0; c < N_CTX; c++) begin
                irq_o[c] <= ctx_any[c] && mode_drives(CTX_MODES[2*c +: 2]);
            end
        end
    end

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned N_CTX = 3,
    parameter int unsigned SRC_W = 3,
    parameter logic [2*N_CTX-1:0] CTX_MODES = 6'b00_01_11
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_en,
    input logic             acc_we,
    input logic [DW-1:0]    acc_rdata,
    input logic             acc_err,
    input logic [N_CTX-1:0] irq_o,
    input logic [N_SRC-1:0] claim_q,
    input logic [N_CTX-1:0] ctx_any,
    input logic             claim_rd,
    input logic             cl_hit,
    input logic [SRC_W-1:0] cl_id,
    input logic             pend_wr
);
    p_claim_marks_r4: assert property (@(posedge clk) disable iff (rst)
        (claim_rd && cl_hit) |=> (claim_q[$past(cl_id)] && acc_rdata == DW'($past(cl_id))));

    p_empty_claim_r4: assert property (@(posedge clk) disable iff (rst)
        (claim_rd && !cl_hit) |=> (acc_rdata == '0));

    p_err_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_we) |=> (!acc_err || acc_rdata == '0));

    p_pend_write_err_r7: assert property (@(posedge clk) disable iff (rst)
        pend_wr |=> acc_err);

    p_src0_unclaimed_r2: assert property (@(posedge clk) disable iff (rst)
        !claim_q[0]);

    for (genvar c = 0; c < N_CTX; c++) begin : g_out
        if (mode_drives(CTX_MODES[2*c +: 2])) begin : g_live
            p_irq_cause_r3: assert property (@(posedge clk) disable iff (rst)
                irq_o[c] |-> $past(ctx_any[c]));
        end else begin : g_mute
            p_irq_mute_r3: assert property (@(posedge clk) disable iff (rst)
                !irq_o[c]);
        end
    end
endmodule

bind irq_hub irq_hub_chk #(
    .N_SRC(N_SRC), .N_CTX(N_CTX), .SRC_W(SRC_W), .CTX_MODES(CTX_MODES)
) u_chk (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_rdata(acc_rdata), .acc_err(acc_err), .irq_o(irq_o),
    .claim_q(claim_q), .ctx_any(ctx_any), .claim_rd(claim_rd),
    .cl_hit(cl_hit), .cl_id(cl_id), .pend_wr(pend_wr)
);

// File: tb/tb_irq_hub.sv
`timescale 1ns/100ps
module tb_irq_hub;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  src_i;
    logic        acc_en, acc_we;
    logic [11:0] acc_addr;
    logic [31:0] acc_wdata;
    logic [31:0] acc_rdata;
    logic        acc_err;
    logic [2:0]  irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    irq_hub dut (
        .clk(clk), .rst(rst), .src_i(src_i), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_err(acc_err), .irq_o(irq_o)
    );

    // {we, addr, wdata, expected rdata, expected err}
    localparam int NV = 17;
    localparam logic [77:0] VEC [NV] = '{
        {1'b1, 12'h004, 32'h0000000D, 32'h0, 1'b0},   // R1 write prio1
        {1'b0, 12'h004, 32'h0,        32'h5, 1'b0},   // R1 low 3 bits kept
        {1'b1, 12'h008, 32'hFFFFFFF3, 32'h0, 1'b0},
        {1'b0, 12'h008, 32'h0,        32'h3, 1'b0},   // R1
        {1'b1, 12'h400, 32'h00000009, 32'h0, 1'b0},   // R6 too large
        {1'b0, 12'h400, 32'h0,        32'h0, 1'b0},   // R6 ignored
        {1'b1, 12'h400, 32'h00000007, 32'h0, 1'b0},   // R6 boundary accepted
        {1'b1, 12'h400, 32'h00000008, 32'h0, 1'b0},
        {1'b0, 12'h400, 32'h0,        32'h7, 1'b0},   // R6 kept 7
        {1'b0, 12'h002, 32'h0,        32'h0, 1'b1},   // R8 misaligned
        {1'b0, 12'h0FC, 32'h0,        32'h0, 1'b1},   // R8 unmapped
        {1'b1, 12'h100, 32'h000000FF, 32'h0, 1'b1},   // R7 pending write error
        {1'b0, 12'h100, 32'h0,        32'h0, 1'b0},   // R7 unchanged
        {1'b1, 12'h200, 32'hFFFFFF06, 32'h0, 1'b0},
        {1'b0, 12'h200, 32'h0,        32'h6, 1'b0},   // R11 low bits kept
        {1'b0, 12'h204, 32'h0,        32'h0, 1'b1},   // R8 enable word beyond count
        {1'b0, 12'h408, 32'h0,        32'h0, 1'b1}    // R8 bad context offset
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [11:0] a, input logic [31:0] d);
        acc_en = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        acc(1'b0, a, 32'h0);
        check(tag, {acc_rdata[31:1], acc_rdata[0] | acc_err}, exp | 32'(acc_err));
        check({tag, " err"}, 32'(acc_err), 32'h0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; src_i = '0; acc_en = 0; acc_we = 0; acc_addr = '0; acc_wdata = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 irq after reset", 32'(irq_o), 32'h0);
        check("R10 rdata after reset", acc_rdata, 32'h0);
        check("R10 err after reset", 32'(acc_err), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        rd_chk("R10 prio reads zero", 12'h010, 32'h0);
        rd_chk("R4 empty claim", 12'h404, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [77:0] v;
            v = VEC[i];
            acc(v[77], v[76:65], v[64:33]);
            check($sformatf("vector %0d rdata", i), acc_rdata, v[32:1]);
            check($sformatf("vector %0d err", i), 32'(acc_err), 32'(v[0]));
        end

        // Setup: prio1=5 prio2=3 prio3=1 prio4=6, sources 1..4 enabled everywhere, thresholds 0
        acc(1, 12'h400, 0);
        acc(1, 12'h00C, 1);
        acc(1, 12'h010, 6);
        acc(1, 12'h200, 32'h1E);
        acc(1, 12'h220, 32'h1E);
        acc(1, 12'h240, 32'h1E);

        // R3 output latency and mode gating, R9 rise sets pending
        src_i = 8'h14;
        @(negedge clk);
        check("R3 irq not yet high", 32'(irq_o), 32'h0);
        @(negedge clk);
        check("R3 irq one cycle later, user ctx low", 32'(irq_o), 32'h3);
        rd_chk("R9 pending follows rise", 12'h100, 32'h14);

        // R4 lowest index wins over higher priority; R5 global mask
        rd_chk("R4 claim lowest index", 12'h404, 32'h2);
        rd_chk("R5 other ctx skips claimed", 12'h414, 32'h4);
        @(negedge clk);
        check("R3 irq drops after claims", 32'(irq_o), 32'h0);
        rd_chk("R4 claim cleared pending", 12'h100, 32'h0);
        rd_chk("R9 held-high source not re-pended", 12'h100, 32'h0);

        // R5 re-raise while claimed stays masked, completion from another context
        src_i = 8'h10; @(negedge clk);
        src_i = 8'h14; @(negedge clk);
        rd_chk("R5 claimed source masked", 12'h404, 32'h0);
        acc(1, 12'h414, 2);
        rd_chk("R5 complete via other ctx", 12'h404, 32'h2);

        // R5 out-of-range complete ignored
        src_i = 8'h04; @(negedge clk);
        src_i = 8'h14; @(negedge clk);
        acc(1, 12'h404, 12);
        rd_chk("R5 id >= count ignored", 12'h414, 32'h0);
        acc(1, 12'h404, 4);
        rd_chk("R5 complete releases 4", 12'h414, 32'h4);

        // R2 strict threshold compare
        acc(1, 12'h404, 2);
        acc(1, 12'h404, 4);
        src_i = 8'h00; @(negedge clk);
        acc(1, 12'h400, 5);
        src_i = 8'h12; @(negedge clk);
        rd_chk("R2 prio equal to threshold skipped", 12'h404, 32'h4);
        rd_chk("R2 zero threshold takes 1", 12'h414, 32'h1);

        // R3 user ctx can still claim but output low
        acc(1, 12'h404, 1);
        acc(1, 12'h404, 4);
        src_i = 8'h00; @(negedge clk);
        src_i = 8'h08; @(negedge clk);
        @(negedge clk);
        check("R3 user ctx output low", 32'(irq_o), 32'h2);
        rd_chk("R9 pending on source 3", 12'h100, 32'h08);
        src_i = 8'h00; @(negedge clk);
        rd_chk("R9 fall clears pending", 12'h100, 32'h0);
        rd_chk("R9 nothing to claim", 12'h424, 32'h0);
        src_i = 8'h08; @(negedge clk);
        rd_chk("R3 user ctx claims", 12'h424, 32'h3);

        // R2 reserved source 0
        acc(1, 12'h000, 7);
        acc(1, 12'h220, 32'h1F);
        src_i = 8'h09; @(negedge clk);
        rd_chk("R2 source 0 never pending", 12'h100, 32'h0);
        rd_chk("R2 source 0 never claimed", 12'h414, 32'h0);

        // R10 mid-run reset
        rst = 1'b1; @(negedge clk); rst = 1'b0; src_i = '0; @(negedge clk);
        rd_chk("R10 prio cleared", 12'h004, 32'h0);
        rd_chk("R10 enable cleared", 12'h220, 32'h0);
        check("R10 irq cleared", 32'(irq_o), 32'h0);

        finish_run();
    end
endmodule